// File: doc/BRIEF.md
# Phase-Detector Reference Selector with Oscillator Divider

This block makes the reference for a clock synthesizer's phase detector. Two sources are available. The first is a horizontal-sync level that has already been conditioned upstream. The second is the oscillator clock, divided by a programmable modulus. A select input picks one of the two sources. A polarity input picks which edge of the chosen source counts as the reference event. The block marks each reference event with a strobe that is one oscillator clock wide, and the downstream detector uses that strobe.

The block also drives a single status pin. Two enable inputs choose what the pin shows: a constant low, the phase-aligner lock flag, the loop lock flag, or the raw reference itself. When the pin shows the raw reference, it carries the divider pulse if the divider is selected, or the sampled sync level XORed with the polarity bit if sync is selected. Both lock flags come from outside the block.

The divider is a two-state machine. In `DIV_HIGH` it drives the divided output high for one oscillator cycle, loads its down-counter from the programmed value, and always takes the `HIGH_TO_LOW` transition. In `DIV_LOW` it counts down and holds `LOW_HOLD` while the counter is nonzero. It takes the `LOW_TO_HIGH` transition at terminal count zero. Reset enters `DIV_LOW` with the counter at zero, so the first pulse comes one clock after reset is released.

Top module: `ref_clk_select`

## Requirements
- R1: With programmed divider value V (7 bits), the divided output repeats every V+2 oscillator cycles. V=0 gives 2 cycles and V=127 gives 129 cycles.
- R2: In each divider period, the divided output is high for exactly one oscillator cycle.
- R3: `in_sel`=1 takes the reference from the divider and `in_sel`=0 takes it from `hsync_in`. Activity on the source that is not selected produces no strobe.
- R4: `ref_pol`=0 makes the rising edge of the selected source the reference event, and `ref_pol`=1 makes the falling edge the event. `hsync_in` is sampled at a clock edge, and the strobe appears at the following edge. For the divider, the strobe follows the edge at which the pulse begins (rising) or ends (falling).
- R5: `ref_strobe` is never high for two consecutive cycles.
- R6: A new divider value is taken only in the cycle the divided output is high. A period that is already running finishes with its old length.
- R7: With `stat_pll_en`=0 and `stat_dpa_en`=0, `stat_out` is 0.
- R8: With `stat_pll_en`=0 and `stat_dpa_en`=1, `stat_out` follows `dpa_lock`.
- R9: With `stat_pll_en`=1 and `stat_dpa_en`=0, `stat_out` follows `pll_lock`.
- R10: With both enables set to 1, `stat_out` is the divided output when `in_sel`=1. When `in_sel`=0, it is the sampled sync level XOR `ref_pol`.
- R11: While `rst_n` is low, `ref_strobe` is 0 and the divided output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock, the only clock of the block |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_in | input | 1 | Conditioned sync level |
| div_val | input | 7 | Divider setting; modulus is this value plus 2 |
| in_sel | input | 1 | Reference source: 1 divider, 0 sync |
| ref_pol | input | 1 | Reference edge: 0 rising, 1 falling |
| stat_pll_en | input | 1 | Status mode select, upper bit |
| stat_dpa_en | input | 1 | Status mode select, lower bit |
| pll_lock | input | 1 | Loop lock flag |
| dpa_lock | input | 1 | Phase-aligner lock flag |
| ref_strobe | output | 1 | One-cycle reference event strobe |
| stat_out | output | 1 | Status pin level |

## Verification
A bad count or a bad reload in the divider shows up at the ports as a wrong spacing between strobes, or as a wrong number of high cycles on the status pin in raw-reference mode. Either error appears within one divider period, at most 129 cycles. An error in the edge logic shows up as a strobe that is missing, doubled or a cycle late, two edges after the stimulus. A wrong status-mux leg is visible on the pin in the same cycle. Because of this, the bench sweeps every divider value and checks every status mode.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
    typedef enum logic {
        DIV_LOW  = 1'b0,
        DIV_HIGH = 1'b1
    } div_state_e;

    typedef enum logic [1:0] {
        STAT_OFF = 2'b00,
        STAT_DPA = 2'b01,
        STAT_PLL = 2'b10,
        STAT_REF = 2'b11
    } stat_mode_e;
endpackage

// File: rtl/osc_div_fsm.sv
module osc_div_fsm
    import ref_sel_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             div_pulse
);
    div_state_e       state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIV_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: LOW_HOLD, LOW_TO_HIGH, HIGH_TO_LOW
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DIV_LOW: begin
                if (cnt_q == '0) begin
                    state_d = DIV_HIGH;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            DIV_HIGH: begin
                state_d = DIV_LOW;
                cnt_d   = div_val;   // low phase lasts div_val+1 cycles
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            DIV_LOW:  div_pulse = 1'b0;
            DIV_HIGH: div_pulse = 1'b1;
        endcase
    end
endmodule

// File: rtl/ref_edge_sel.sv
module ref_edge_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    input  logic div_pulse,
    input  logic in_sel,
    input  logic ref_pol,
    output logic hsync_q,
    output logic ref_strobe
);
    logic src_lvl;
    logic lvl_prev;

    always_comb begin
        src_lvl = (in_sel ? div_pulse : hsync_q) ^ ref_pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync_q    <= 1'b0;
            lvl_prev   <= 1'b1;   // no event until a real low-to-high is seen
            ref_strobe <= 1'b0;
        end else begin
            hsync_q    <= hsync_in;
            lvl_prev   <= src_lvl;
            ref_strobe <= src_lvl & ~lvl_prev;
        end
    end
endmodule

// File: rtl/stat_mux.sv
module stat_mux
    import ref_sel_pkg::*;
(
    input  logic stat_pll_en,
    input  logic stat_dpa_en,
    input  logic pll_lock,
    input  logic dpa_lock,
    input  logic in_sel,
    input  logic ref_pol,
    input  logic hsync_q,
    input  logic div_pulse,
    output logic stat_out
);
    stat_mode_e mode;

    always_comb begin
        mode = stat_mode_e'({stat_pll_en, stat_dpa_en});
        unique case (mode)
            STAT_OFF: stat_out = 1'b0;
            STAT_DPA: stat_out = dpa_lock;
            STAT_PLL: stat_out = pll_lock;
            STAT_REF: stat_out = in_sel ? div_pulse : (hsync_q ^ ref_pol);
        endcase
    end
endmodule

// File: rtl/ref_clk_select.sv
module ref_clk_select #(
    parameter int DIV_W = 7
) (
    input  logic             clk_osc,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic [DIV_W-1:0] div_val,
    input  logic             in_sel,
    input  logic             ref_pol,
    input  logic             stat_pll_en,
    input  logic             stat_dpa_en,
    input  logic             pll_lock,
    input  logic             dpa_lock,
    output logic             ref_strobe,
    output logic             stat_out
);
    logic div_pulse;
    logic hsync_q;

    osc_div_fsm #(.DIV_W(DIV_W)) u_div (
        .clk       (clk_osc),
        .rst_n     (rst_n),
        .div_val   (div_val),
        .div_pulse (div_pulse)
    );

    ref_edge_sel u_edge (
        .clk        (clk_osc),
        .rst_n      (rst_n),
        .hsync_in   (hsync_in),
        .div_pulse  (div_pulse),
        .in_sel     (in_sel),
        .ref_pol    (ref_pol),
        .hsync_q    (hsync_q),
        .ref_strobe (ref_strobe)
    );

    stat_mux u_stat (
        .stat_pll_en (stat_pll_en),
        .stat_dpa_en (stat_dpa_en),
        .pll_lock    (pll_lock),
        .dpa_lock    (dpa_lock),
        .in_sel      (in_sel),
        .ref_pol     (ref_pol),
        .hsync_q     (hsync_q),
        .div_pulse   (div_pulse),
        .stat_out    (stat_out)
    );
endmodule

// File: rtl/ref_clk_select_chk.sv
module ref_clk_select_chk #(
    parameter int DIV_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_val,
    input logic             in_sel,
    input logic             ref_pol,
    input logic             stat_pll_en,
    input logic             stat_dpa_en,
    input logic             pll_lock,
    input logic             dpa_lock,
    input logic             div_pulse,
    input logic             ref_strobe,
    input logic             stat_out
);
    localparam int GAP_W = DIV_W + 1;

    logic [GAP_W-1:0] gap;
    logic [GAP_W-1:0] mod_exp;
    logic             seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap     <= '0;
            mod_exp <= '0;
            seen    <= 1'b0;
        end else if (div_pulse) begin
            gap     <= GAP_W'(1);
            mod_exp <= GAP_W'(div_val) + GAP_W'(2);
            seen    <= 1'b1;
        end else begin
            gap     <= gap + 1'b1;
        end
    end

    // R1 and R6: spacing equals the modulus taken in the previous pulse
    a_r1_period: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && seen) |-> (gap == mod_exp));

    a_r2_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    a_r4_div_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sel && !ref_pol && $stable(in_sel) && $stable(ref_pol) && $rose(div_pulse))
        |=> ref_strobe);

    a_r5_strobe_one: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |=> !ref_strobe);

    a_r7_stat_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_pll_en && !stat_dpa_en) |-> !stat_out);

    a_r8_stat_dpa: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_pll_en && stat_dpa_en) |-> (stat_out == dpa_lock));

    a_r9_stat_pll: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_pll_en && !stat_dpa_en) |-> (stat_out == pll_lock));

    a_r10_stat_div: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_pll_en && stat_dpa_en && in_sel) |-> (stat_out == div_pulse));

    always_comb begin
        if (!rst_n) begin
            a_r11_reset_quiet: assert (!ref_strobe && !div_pulse);
        end
    end
endmodule

bind ref_clk_select ref_clk_select_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk_osc),
    .rst_n       (rst_n),
    .div_val     (div_val),
    .in_sel      (in_sel),
    .ref_pol     (ref_pol),
    .stat_pll_en (stat_pll_en),
    .stat_dpa_en (stat_dpa_en),
    .pll_lock    (pll_lock),
    .dpa_lock    (dpa_lock),
    .div_pulse   (div_pulse),
    .ref_strobe  (ref_strobe),
    .stat_out    (stat_out)
);

// File: tb/tb_ref_clk_select.sv
module tb_ref_clk_select;
    logic       clk_osc = 1'b0;
    logic       rst_n;
    logic       hsync_in;
    logic [6:0] div_val;
    logic       in_sel, ref_pol, stat_pll_en, stat_dpa_en, pll_lock, dpa_lock;
    logic       ref_strobe, stat_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk_osc = ~clk_osc;

    ref_clk_select dut (
        .clk_osc(clk_osc), .rst_n(rst_n), .hsync_in(hsync_in), .div_val(div_val),
        .in_sel(in_sel), .ref_pol(ref_pol), .stat_pll_en(stat_pll_en),
        .stat_dpa_en(stat_dpa_en), .pll_lock(pll_lock), .dpa_lock(dpa_lock),
        .ref_strobe(ref_strobe), .stat_out(stat_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk_osc);
    endtask

    // steps until ref_strobe is seen; returns the number of steps taken
    task automatic wait_strobe(output int cyc, output int highs);
        cyc = 0;
        highs = 0;
        do begin
            step();
            cyc++;
            if (stat_out) highs++;
        end while (!ref_strobe && cyc < 400);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            finish_run();
        end
    end

    initial begin
        int cyc, highs, strobes;
        rst_n = 1'b0; hsync_in = 1'b0; div_val = 7'd0; in_sel = 1'b1; ref_pol = 1'b0;
        stat_pll_en = 1'b1; stat_dpa_en = 1'b1; pll_lock = 1'b0; dpa_lock = 1'b0;
        repeat (3) step();
        check("R11 strobe in reset", ref_strobe, 0);
        check("R11 divider low in reset", stat_out, 0);
        rst_n = 1'b1;

        // R1/R2: sweep every divider value
        for (int v = 0; v < 128; v++) begin
            div_val = 7'(v);
            wait_strobe(cyc, highs);
            wait_strobe(cyc, highs);
            check("R1 period", cyc, v + 2);
            check("R2 high cycles", highs, 1);
        end

        // R6: change mid-period keeps old length once
        div_val = 7'd10;
        wait_strobe(cyc, highs);
        wait_strobe(cyc, highs);
        div_val = 7'd3;
        wait_strobe(cyc, highs);
        check("R6 running period kept", cyc, 12);
        wait_strobe(cyc, highs);
        check("R6 new period", cyc, 5);

        // R4: falling edge of divider: strobe one cycle later than rising
        ref_pol = 1'b1;
        wait_strobe(cyc, highs);
        wait_strobe(cyc, highs);
        check("R4 falling-edge divider period", cyc, 5);
        check("R10 divider on status", highs, 1);
        ref_pol = 1'b0;

        // R3: hsync toggles ignored with divider selected
        div_val = 7'd127;
        wait_strobe(cyc, highs);
        wait_strobe(cyc, highs);
        strobes = 0;
        for (int i = 0; i < 100; i++) begin
            if (i % 3 == 0) hsync_in = ~hsync_in;
            step();
            if (ref_strobe) strobes++;
        end
        check("R3 hsync ignored", strobes, 0);

        // R3: divider ignored with hsync selected
        hsync_in = 1'b0;
        div_val = 7'd2;
        in_sel = 1'b0;
        repeat (4) step();
        strobes = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (ref_strobe) strobes++;
        end
        check("R3 divider ignored", strobes, 0);

        // R4/R5: hsync rising edge, pol 0
        hsync_in = 1'b1;
        step(); check("R4 rise latency 1", ref_strobe, 0);
        check("R10 hsync level on status", stat_out, 1);
        step(); check("R4 rise strobe", ref_strobe, 1);
        step(); check("R5 strobe one wide", ref_strobe, 0);
        hsync_in = 1'b0;
        strobes = 0;
        for (int i = 0; i < 4; i++) begin step(); if (ref_strobe) strobes++; end
        check("R4 fall ignored with pol 0", strobes, 0);
        check("R10 hsync low on status", stat_out, 0);

        // R4: pol 1, falling edge
        ref_pol = 1'b1;
        repeat (4) step();
        check("R10 hsync xor pol", stat_out, 1);
        hsync_in = 1'b1;
        strobes = 0;
        for (int i = 0; i < 4; i++) begin step(); if (ref_strobe) strobes++; end
        check("R4 rise ignored with pol 1", strobes, 0);
        hsync_in = 1'b0;
        step(); check("R4 fall latency 1", ref_strobe, 0);
        step(); check("R4 fall strobe", ref_strobe, 1);
        step(); check("R5 fall strobe one wide", ref_strobe, 0);

        // R7..R9: status modes
        stat_pll_en = 1'b0; stat_dpa_en = 1'b0; pll_lock = 1'b1; dpa_lock = 1'b1;
        step(); #1; check("R7 status off", stat_out, 0);
        stat_dpa_en = 1'b1; pll_lock = 1'b0; dpa_lock = 1'b1;
        #1; check("R8 dpa lock high", stat_out, 1);
        pll_lock = 1'b1; dpa_lock = 1'b0;
        #1; check("R8 dpa lock low", stat_out, 0);
        stat_pll_en = 1'b1; stat_dpa_en = 1'b0; pll_lock = 1'b1; dpa_lock = 1'b0;
        #1; check("R9 pll lock high", stat_out, 1);
        pll_lock = 1'b0; dpa_lock = 1'b1;
        #1; check("R9 pll lock low", stat_out, 0);

        done = 1'b1;
        finish_run();
    end
endmodule